// File: doc/BRIEF.md
# ADC Result Transfer DMA Controller

This block moves every fresh converter result into a region of system memory without processor involvement. Results arrive on a valid/ready stream; each accepted word becomes one memory write request, and the write port follows a request/grant handshake. The region is either one block of `n` words, or two back-to-back blocks of `n` words each used as a ping-pong pair. A flag records which half was filled most recently. An optional continuous mode wraps the pointer back to the start address once the region is full. Without it, the controller stops at that point.

Software programs the transfer count, the start address and the two mode bits, then pulses `cfg_load`. That pulse loads the settings, flushes any queued result and restarts the transfer at the start address. A count of zero leaves the controller disabled. The completion flag `done_irq` is raised each time a block finishes and stays high until `irq_clr` is pulsed. `cpu_stall` is high in every cycle in which a write is granted, so the processor is held off for exactly one clock per transfer.

Back-pressure rules: a result is taken on any clock edge where `res_valid` and `res_ready` are both high. `res_ready` is low only when the one-entry holding buffer is occupied, which happens when a result arrives while the previous write is still waiting for its grant. Once `wr_req` is high, it stays high with `wr_addr` and `wr_data` unchanged until a cycle with `wr_gnt` high. When the controller is disabled or has stopped, results are still accepted but are discarded.

Top module: `adc_result_dma`

## Requirements
- R1: After `cfg_load` with `cfg_count` = 0, no memory write is ever requested, and results are accepted (`res_ready` = 1) and discarded.
- R2: In one-block mode (`cfg_two_blk` = 0) with continuous off, the k-th accepted result (k = 0..n-1) is written to byte address base + 2k, in arrival order. Later results are never written.
- R3: In two-block mode (`cfg_two_blk` = 1) with continuous off, the first n results go to base .. base+2n-2 and the next n go to base+2n .. base+4n-2. Then writing stops.
- R4: Bit 0 of `cfg_base` is ignored: the base is `cfg_base` with bit 0 cleared, and `wr_addr[0]` is always 0.
- R5: With `cfg_cont` = 1, the write after the last word of the region goes to the base address again. This repeats indefinitely.
- R6: `blk1_filled` is 0 after reset, becomes 1 when the first block completes, and becomes 0 when the second block completes.
- R7: `done_irq` rises only on the write that completes a block, never on earlier writes. It stays high until `irq_clr`, which clears it.
- R8: `cpu_stall` is high exactly in the cycles where `wr_req` and `wr_gnt` are both high.
- R9: While a grant is withheld, one further result is buffered, after which `res_ready` is 0. The waiting request holds its address and data stable, and no accepted result is lost.
- R10: After reset, `wr_req`, `cpu_stall`, `done_irq` and `blk1_filled` are 0, `res_ready` is 1, and the controller is disabled until `cfg_load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Converter result valid |
| res_data | input | 16 | Converter result word |
| res_ready | output | 1 | Result can be accepted |
| cfg_load | input | 1 | Pulse: latch settings and restart at the base address |
| cfg_count | input | 8 | Words per block; 0 disables |
| cfg_base | input | 16 | Start byte address (bit 0 ignored) |
| cfg_two_blk | input | 1 | 1 = ping-pong pair of blocks |
| cfg_cont | input | 1 | 1 = wrap to the base address after the region fills |
| irq_clr | input | 1 | Pulse: clear the completion flag |
| wr_req | output | 1 | Memory write request |
| wr_gnt | input | 1 | Memory write grant |
| wr_addr | output | 16 | Write byte address (word aligned) |
| wr_data | output | 16 | Write data |
| cpu_stall | output | 1 | Processor stall, high during each granted write |
| blk1_filled | output | 1 | 1 = first block filled last, 0 = second block |
| done_irq | output | 1 | Completion flag, set at each block end |

## Verification
The bench goes after the block boundaries. A design that reloads the pointer at the wrong moment would write the second block over the first, or wrap one word early or late. A design that raises the completion flag per result would show it after the first write. A design that keeps running after a non-continuous region would write the extra results it receives. Withholding the grant exposes a design that drops or reorders a result arriving behind a pending write, or that lets the address move before the grant. The zero-count and odd-base cases catch a controller that writes while disabled or emits an odd address.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;
endpackage

// File: rtl/adc_dma_stage.sv
// Write stage plus one-entry holding buffer between result stream and memory port.
module adc_dma_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          enable,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          wr_req,
  output logic [DW-1:0] wr_data,
  input  logic          wr_gnt,
  output logic          fire
);
  logic          buf_vld;
  logic [DW-1:0] buf_data;
  logic          take;
  logic          slot_free;

  assign in_ready  = !buf_vld;
  assign take      = in_valid && in_ready && enable;
  assign fire      = wr_req && wr_gnt;
  assign slot_free = !wr_req || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req   <= 1'b0;
      wr_data  <= '0;
      buf_vld  <= 1'b0;
      buf_data <= '0;
    end else if (flush) begin
      wr_req  <= 1'b0;
      buf_vld <= 1'b0;
    end else if (slot_free) begin
      if (buf_vld) begin
        wr_req   <= 1'b1;
        wr_data  <= buf_data;
        buf_vld  <= take;
        buf_data <= in_data;
      end else begin
        wr_req  <= take;
        wr_data <= in_data;
      end
    end else if (take) begin
      buf_vld  <= 1'b1;
      buf_data <= in_data;
    end
  end
endmodule

// File: rtl/adc_dma_sched.sv
// Pointer, per-block counter, block phase and status flags.
module adc_dma_sched
  import adc_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_base,
  input  logic          cfg_two_blk,
  input  logic          cfg_cont,
  input  logic          beat,
  input  logic          irq_clr,
  output logic          running,
  output logic          stop_now,
  output logic [AW-1:0] wr_addr,
  output logic          blk1_filled,
  output logic          done_irq
);
  localparam int PW = AW - 1;

  logic [CW-1:0] n_q, left_q;
  logic [PW-1:0] base_q, ptr_q;
  logic          two_q, cont_q;
  phase_e        phase_q;
  logic          blk_end;

  assign blk_end  = beat && (left_q == CW'(1));
  assign stop_now = blk_end && !cont_q && (!two_q || phase_q == PH_SECOND);
  assign wr_addr  = {ptr_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q         <= '0;
      left_q      <= '0;
      base_q      <= '0;
      ptr_q       <= '0;
      two_q       <= 1'b0;
      cont_q      <= 1'b0;
      phase_q     <= PH_FIRST;
      running     <= 1'b0;
      blk1_filled <= 1'b0;
    end else if (cfg_load) begin
      n_q     <= cfg_count;
      left_q  <= cfg_count;
      base_q  <= cfg_base[AW-1:1];
      ptr_q   <= cfg_base[AW-1:1];
      two_q   <= cfg_two_blk;
      cont_q  <= cfg_cont;
      phase_q <= PH_FIRST;
      running <= (cfg_count != '0);
    end else if (beat) begin
      if (!blk_end) begin
        ptr_q  <= ptr_q + PW'(1);
        left_q <= left_q - CW'(1);
      end else if (phase_q == PH_FIRST && two_q) begin
        blk1_filled <= 1'b1;
        phase_q     <= PH_SECOND;
        ptr_q       <= ptr_q + PW'(1);
        left_q      <= n_q;
      end else begin
        blk1_filled <= (phase_q == PH_FIRST);
        phase_q     <= PH_FIRST;
        if (cont_q) begin
          ptr_q  <= base_q;
          left_q <= n_q;
        end else begin
          running <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_irq <= 1'b0;
    else if (blk_end) done_irq <= 1'b1;
    else if (irq_clr) done_irq <= 1'b0;
  end
endmodule

// File: rtl/adc_result_dma.sv
module adc_result_dma #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          res_ready,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_base,
  input  logic          cfg_two_blk,
  input  logic          cfg_cont,
  input  logic          irq_clr,
  output logic          wr_req,
  input  logic          wr_gnt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          cpu_stall,
  output logic          blk1_filled,
  output logic          done_irq
);
  logic running, stop_now, fire;

  adc_dma_stage #(.DW(DW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (cfg_load || stop_now),
    .enable   (running),
    .in_valid (res_valid),
    .in_data  (res_data),
    .in_ready (res_ready),
    .wr_req   (wr_req),
    .wr_data  (wr_data),
    .wr_gnt   (wr_gnt),
    .fire     (fire)
  );

  adc_dma_sched #(.AW(AW), .CW(CW)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_count   (cfg_count),
    .cfg_base    (cfg_base),
    .cfg_two_blk (cfg_two_blk),
    .cfg_cont    (cfg_cont),
    .beat        (fire),
    .irq_clr     (irq_clr),
    .running     (running),
    .stop_now    (stop_now),
    .wr_addr     (wr_addr),
    .blk1_filled (blk1_filled),
    .done_irq    (done_irq)
  );

  assign cpu_stall = fire;
endmodule

// File: rtl/adc_result_dma_chk.sv
module adc_result_dma_chk #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_ready,
  input logic          cfg_load,
  input logic          wr_req,
  input logic          wr_gnt,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          cpu_stall,
  input logic          blk1_filled,
  input logic          done_irq,
  input logic          running
);
  p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_addr[0] == 1'b0));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_gnt && !cfg_load) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  p_full_means_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ready |-> wr_req);

  p_stall_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (wr_req && wr_gnt));

  p_idle_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !wr_req);

  p_done_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(cpu_stall));

  p_flag_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(blk1_filled) || $fell(blk1_filled)) |-> $past(cpu_stall));
endmodule

bind adc_result_dma adc_result_dma_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .res_ready   (res_ready),
  .cfg_load    (cfg_load),
  .wr_req      (wr_req),
  .wr_gnt      (wr_gnt),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .cpu_stall   (cpu_stall),
  .blk1_filled (blk1_filled),
  .done_irq    (done_irq),
  .running     (running)
);

// File: tb/adc_result_dma_bench.sv
module adc_result_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        res_ready;
  logic        cfg_load = 1'b0;
  logic [7:0]  cfg_count = '0;
  logic [15:0] cfg_base = '0;
  logic        cfg_two_blk = 1'b0;
  logic        cfg_cont = 1'b0;
  logic        irq_clr = 1'b0;
  logic        wr_req;
  logic        wr_gnt = 1'b1;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic        cpu_stall;
  logic        blk1_filled;
  logic        done_irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [15:0] log_a [0:63];
  logic [15:0] log_d [0:63];
  int nlog = 0;

  always #2.5 clk = ~clk;

  adc_result_dma u_adc_result_dma (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .res_ready(res_ready), .cfg_load(cfg_load), .cfg_count(cfg_count),
    .cfg_base(cfg_base), .cfg_two_blk(cfg_two_blk), .cfg_cont(cfg_cont),
    .irq_clr(irq_clr), .wr_req(wr_req), .wr_gnt(wr_gnt), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_stall(cpu_stall), .blk1_filled(blk1_filled),
    .done_irq(done_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Write monitor and stall rule (R8), sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (cpu_stall !== (wr_req && wr_gnt))
        chk(1'b0, "R8 stall vs granted write", {31'b0, cpu_stall}, {31'b0, wr_req && wr_gnt});
      if (wr_req && wr_gnt && nlog < 64) begin
        log_a[nlog] = wr_addr;
        log_d[nlog] = wr_data;
        nlog++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic configure(input logic [7:0] n, input logic [15:0] base, input bit two, input bit cont);
    cfg_count = n; cfg_base = base; cfg_two_blk = two; cfg_cont = cont;
    cfg_load = 1'b1;
    tick(1);
    cfg_load = 1'b0;
    nlog = 0;
  endtask

  task automatic send(input logic [15:0] d);
    res_valid = 1'b1;
    res_data  = d;
    do @(negedge clk); while (!res_ready);
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  task automatic clear_flag;
    irq_clr = 1'b1;
    tick(1);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk(wr_req == 1'b0, "R10 wr_req after reset", {31'b0, wr_req}, 0);
    chk(cpu_stall == 1'b0, "R10 cpu_stall after reset", {31'b0, cpu_stall}, 0);
    chk(done_irq == 1'b0, "R10 done_irq after reset", {31'b0, done_irq}, 0);
    chk(blk1_filled == 1'b0, "R6 blk1_filled after reset", {31'b0, blk1_filled}, 0);
    chk(res_ready == 1'b1, "R10 res_ready after reset", {31'b0, res_ready}, 1);
    send(16'h0BAD);
    tick(4);
    chk(nlog == 0, "R10 no write before cfg_load", nlog, 0);
  endtask

  task automatic t_zero_count;
    configure(8'd0, 16'h0100, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send(16'h0A00 + 16'(i));
    tick(5);
    chk(nlog == 0, "R1 zero count writes nothing", nlog, 0);
    chk(res_ready == 1'b1, "R1 results still accepted", {31'b0, res_ready}, 1);
  endtask

  task automatic t_one_block;
    configure(8'd4, 16'h1001, 1'b0, 1'b0);
    send(16'h1110);
    tick(3);
    chk(done_irq == 1'b0, "R7 no flag after first result", {31'b0, done_irq}, 0);
    for (int i = 1; i < 6; i++) send(16'h1110 + 16'(i));
    tick(5);
    chk(nlog == 4, "R2 write count single block", nlog, 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_a[i] == 16'h1000 + 16'(2 * i), "R4 R2 address with odd base", log_a[i], 16'h1000 + 16'(2 * i));
      chk(log_d[i] == 16'h1110 + 16'(i), "R2 data order", log_d[i], 16'h1110 + 16'(i));
    end
    chk(done_irq == 1'b1, "R7 flag at block end", {31'b0, done_irq}, 1);
    chk(blk1_filled == 1'b1, "R6 first block filled", {31'b0, blk1_filled}, 1);
    tick(3);
    chk(done_irq == 1'b1, "R7 flag sticky", {31'b0, done_irq}, 1);
    clear_flag();
    chk(done_irq == 1'b0, "R7 flag cleared", {31'b0, done_irq}, 0);
  endtask

  task automatic t_two_block;
    configure(8'd3, 16'h2000, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) send(16'h2200 + 16'(i));
    tick(3);
    chk(blk1_filled == 1'b1, "R6 block one filled", {31'b0, blk1_filled}, 1);
    chk(done_irq == 1'b1, "R7 flag after block one", {31'b0, done_irq}, 1);
    clear_flag();
    send(16'h2203);
    tick(3);
    chk(done_irq == 1'b0, "R7 no flag mid block two", {31'b0, done_irq}, 0);
    for (int i = 4; i < 7; i++) send(16'h2200 + 16'(i));
    tick(5);
    chk(nlog == 6, "R3 write count two blocks", nlog, 6);
    for (int i = 0; i < 6; i++) begin
      chk(log_a[i] == 16'h2000 + 16'(2 * i), "R3 address two blocks", log_a[i], 16'h2000 + 16'(2 * i));
      chk(log_d[i] == 16'h2200 + 16'(i), "R3 data two blocks", log_d[i], 16'h2200 + 16'(i));
    end
    chk(blk1_filled == 1'b0, "R6 block two filled", {31'b0, blk1_filled}, 0);
    chk(done_irq == 1'b1, "R7 flag after block two", {31'b0, done_irq}, 1);
    clear_flag();
  endtask

  task automatic t_continuous;
    configure(8'd2, 16'h0400, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) send(16'h4400 + 16'(i));
    tick(4);
    chk(nlog == 5, "R5 continuous keeps writing", nlog, 5);
    for (int i = 0; i < 5; i++)
      chk(log_a[i] == 16'h0400 + 16'(2 * (i % 2)), "R5 wrap address", log_a[i], 16'h0400 + 16'(2 * (i % 2)));
    clear_flag();
  endtask

  task automatic t_backpressure;
    wr_gnt = 1'b0;
    configure(8'd8, 16'h3000, 1'b0, 1'b0);
    send(16'h3300);
    send(16'h3301);
    res_valid = 1'b1;
    res_data  = 16'h3302;
    @(negedge clk);
    chk(res_ready == 1'b0, "R9 ready low with buffer full", {31'b0, res_ready}, 0);
    chk(wr_req == 1'b1, "R9 request pending", {31'b0, wr_req}, 1);
    chk(cpu_stall == 1'b0, "R8 no stall without grant", {31'b0, cpu_stall}, 0);
    tick(3);
    @(negedge clk);
    chk(wr_addr == 16'h3000, "R9 address held", wr_addr, 16'h3000);
    chk(wr_data == 16'h3300, "R9 data held", wr_data, 16'h3300);
    @(posedge clk); #1;
    wr_gnt = 1'b1;
    do @(negedge clk); while (!res_ready);
    @(posedge clk); #1;
    res_valid = 1'b0;
    tick(5);
    chk(nlog == 3, "R9 no result lost", nlog, 3);
    for (int i = 0; i < 3; i++) begin
      chk(log_d[i] == 16'h3300 + 16'(i), "R9 data order", log_d[i], 16'h3300 + 16'(i));
      chk(log_a[i] == 16'h3000 + 16'(2 * i), "R9 address order", log_a[i], 16'h3000 + 16'(2 * i));
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_zero_count();
    t_one_block();
    t_two_block();
    t_continuous();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule